// File: doc/BRIEF.md
# Supply Brown-out Sequencer

This block turns three digital supply comparator flags into an internal CPU reset, a qualified low-supply warning and the enables for the supply monitor, the core regulator and the crystal oscillator. The flags report the supply below the warning level, below the brown-out level and below the power-on level. The block runs on the system clock. A one-cycle strobe, synchronous to that clock, marks each period of the slow always-on ring oscillator.

During a brown-out reset the monitor can stay on all the time, or it can be powered only for short sampling windows spaced a selectable number of ring periods apart. The CPU leaves reset only after two checks. A sampling window must find the supply good, and the supply must then stay good for one more ring period. A crystal warm-up count follows. Resets from other sources keep the regulator and oscillator running and end within a few clocks. In stop mode a configuration bit can switch the monitor off. When stop is left, the monitor is turned back on for a start-up time before the CPU resumes.

Top module: `pwr_guard_seq`

## Requirements
- R1: While `below_por_i` is high, from the next cycle `cpu_rst_o`=1 and `reg_en_o`, `osc_en_o` and `mon_en_o` are all 0. The same outputs hold during `rst_ni` low.
- R2: In normal run, `below_rst_i` high puts `cpu_rst_o` to 1 on the next cycle with `osc_en_o`=0. With `ivl_sel_i`=0 the monitor then stays on (`mon_en_o`=1).
- R3: `ivl_sel_i` selects the reset-time sampling: 0 gives continuous monitoring; 1, 2 and 3 give 2^11, 2^12 and 2^13 ring ticks between windows. The rise-to-rise period of `mon_en_o` is therefore (2^(10+sel)+2) ring ticks.
- R4: Each sampling window keeps `mon_en_o` and `reg_en_o` high for exactly two ring ticks, with `osc_en_o`=0.
- R5: A window that ends with `below_rst_i` low keeps the monitor on for one more ring tick. If `below_rst_i` is still low at that tick, warm-up starts. If it is high, the block returns to sampling and stays in reset.
- R6: Warm-up drives `osc_en_o`=1. `cpu_rst_o` falls exactly WARM_CYC clocks after `osc_en_o` rises.
- R7: `warn_flag_o` sets once `below_warn_i`=1 with `below_rst_i`=0 has held for QUAL_CYC consecutive clocks while monitoring is active. Shorter runs leave the flag unchanged. The flag stays set until `warn_clr_i`.
- R8: `warn_irq_o` is `warn_flag_o` gated by `warn_irq_en_i`.
- R9: `ext_rst_i` asserts `cpu_rst_o` on the next cycle while the regulator, oscillator and monitor stay on. `cpu_rst_o` falls EXT_CYC (at most 20) clocks after `ext_rst_i` falls.
- R10: The stop-monitor-off bit resets to 1 and is written through `cfg_we_i`/`cfg_stop_dis_i`. While it is 1, stop mode drives the monitor, regulator and oscillator off, and `below_warn_i`/`below_rst_i` have no effect.
- R11: `wake_i` in stop turns the monitor, regulator and oscillator on, and `in_stop_o` stays high for MON_UP_CYC clocks. At the end of that time, `below_rst_i` high causes a reset and `below_warn_i` high sets `warn_flag_o`.
- R12: With the stop-monitor-off bit at 0, the monitor stays on in stop and `below_rst_i` asserts `cpu_rst_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ring_tick_i | input | 1 | One-cycle strobe per ring-oscillator period |
| below_warn_i | input | 1 | Supply below warning level |
| below_rst_i | input | 1 | Supply below brown-out reset level |
| below_por_i | input | 1 | Supply below power-on level |
| ext_rst_i | input | 1 | Reset request from another source |
| stop_req_i | input | 1 | Enter stop mode |
| wake_i | input | 1 | Wake event in stop |
| ivl_sel_i | input | 2 | Reset-time sampling interval select |
| warn_irq_en_i | input | 1 | Warning interrupt enable |
| warn_clr_i | input | 1 | Clear warning flag |
| cfg_we_i | input | 1 | Write strobe for stop-monitor-off bit |
| cfg_stop_dis_i | input | 1 | Value for stop-monitor-off bit |
| cpu_rst_o | output | 1 | CPU held in reset |
| in_stop_o | output | 1 | CPU stopped |
| mon_en_o | output | 1 | Supply monitor power enable |
| reg_en_o | output | 1 | Core regulator enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| warn_flag_o | output | 1 | Qualified low-supply warning flag |
| warn_irq_o | output | 1 | Warning interrupt |

## Verification
The hardest path to reach is a confirmation tick that fails after a clean sampling window. The supply flag must be good when the window closes and then go bad before the next ring tick. The stimulus waits for the rising edge of `mon_en_o` and clears `below_rst_i` inside the window. It then raises `below_rst_i` again one cycle after the window's second tick, so that the confirmation tick samples it high. The periods at the longer intervals are measured edge to edge on `mon_en_o`. Warning pulse lengths are drawn at random around the qualification threshold.

// File: rtl/pwr_guard_pkg.sv
`timescale 1ns/1ps
package pwr_guard_pkg;
  typedef enum logic [2:0] {
    ST_POR, ST_PFRST, ST_PFCONF, ST_WARM, ST_RUN, ST_EXTRST, ST_STOP, ST_WAKE
  } pg_state_e;

  typedef struct packed {
    logic cpu_rst;
    logic reg_en;
    logic osc_en;
    logic mon_en;
    logic in_stop;
  } pg_drv_t;
endpackage

// File: rtl/pwr_guard_sampler.sv
`timescale 1ns/1ps
module pwr_guard_sampler #(
  parameter int IVL_LOG = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       act_i,
  input  logic [1:0] sel_i,
  output logic       win_o,
  output logic       eval_o
);
  localparam int CW = IVL_LOG + 3;

  logic          in_win_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          cont;

  assign cont = (sel_i == 2'd0);

  always_comb begin
    lim = (CW'(1) << (IVL_LOG + int'(sel_i) - 1)) - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_win_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!act_i) begin
      in_win_q <= cont;
      cnt_q    <= '0;
    end else if (tick_i) begin
      if (in_win_q) begin
        if (cnt_q == CW'(1)) begin
          cnt_q    <= '0;
          in_win_q <= cont;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else if (cnt_q >= lim) begin
        in_win_q <= 1'b1;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign win_o  = act_i && in_win_q;
  assign eval_o = win_o && tick_i && (cnt_q == CW'(1));
endmodule

// File: rtl/pwr_guard_qual.sv
`timescale 1ns/1ps
module pwr_guard_qual #(
  parameter int QUAL_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic hit_o
);
  localparam int QW = $clog2(QUAL_CYC + 1);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!cond_i)                  cnt_q <= '0;
    else if (cnt_q != QW'(QUAL_CYC))   cnt_q <= cnt_q + QW'(1);
  end

  assign hit_o = cond_i && (cnt_q >= QW'(QUAL_CYC - 1));
endmodule

// File: rtl/pwr_guard_delay.sv
`timescale 1ns/1ps
module pwr_guard_delay #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_guard_seq.sv
`timescale 1ns/1ps
module pwr_guard_seq
  import pwr_guard_pkg::*;
#(
  parameter int IVL_LOG    = 11,
  parameter int QUAL_CYC   = 64,
  parameter int WARM_CYC   = 200,
  parameter int EXT_CYC    = 16,
  parameter int MON_UP_CYC = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ring_tick_i,
  input  logic       below_warn_i,
  input  logic       below_rst_i,
  input  logic       below_por_i,
  input  logic       ext_rst_i,
  input  logic       stop_req_i,
  input  logic       wake_i,
  input  logic [1:0] ivl_sel_i,
  input  logic       warn_irq_en_i,
  input  logic       warn_clr_i,
  input  logic       cfg_we_i,
  input  logic       cfg_stop_dis_i,
  output logic       cpu_rst_o,
  output logic       in_stop_o,
  output logic       mon_en_o,
  output logic       reg_en_o,
  output logic       osc_en_o,
  output logic       warn_flag_o,
  output logic       warn_irq_o
);
  localparam int DMAX_A = (WARM_CYC > EXT_CYC) ? WARM_CYC : EXT_CYC;
  localparam int DMAX   = (DMAX_A > MON_UP_CYC) ? DMAX_A : MON_UP_CYC;
  localparam int DW     = $clog2(DMAX + 1);

  pg_state_e     state_q, state_d;
  pg_drv_t       drv;
  logic          stop_dis_q;
  logic          warn_q;
  logic          win, eval;
  logic          qual_cond, qual_hit;
  logic          dly_load, dly_done;
  logic [DW-1:0] dly_val;
  logic          mon_stop;
  logic          wake_warn;

  assign mon_stop = !stop_dis_q;

  pwr_guard_sampler #(.IVL_LOG(IVL_LOG)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ring_tick_i),
    .act_i  (state_q == ST_PFRST),
    .sel_i  (ivl_sel_i),
    .win_o  (win),
    .eval_o (eval)
  );

  assign qual_cond = below_warn_i && !below_rst_i &&
                     ((state_q == ST_RUN) || ((state_q == ST_STOP) && mon_stop));

  pwr_guard_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (qual_cond),
    .hit_o  (qual_hit)
  );

  pwr_guard_delay #(.W(DW)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dly_load),
    .val_i  (dly_val),
    .done_o (dly_done)
  );

  always_comb begin
    state_d = state_q;
    if (below_por_i) begin
      state_d = ST_POR;
    end else begin
      unique case (state_q)
        ST_POR:    state_d = ST_PFRST;
        ST_PFRST:  if (eval && !below_rst_i) state_d = ST_PFCONF;
        ST_PFCONF: if (ring_tick_i) state_d = below_rst_i ? ST_PFRST : ST_WARM;
        ST_WARM: begin
          if (below_rst_i)   state_d = ST_PFRST;
          else if (dly_done) state_d = ST_RUN;
        end
        ST_RUN: begin
          if (below_rst_i)     state_d = ST_PFRST;
          else if (ext_rst_i)  state_d = ST_EXTRST;
          else if (stop_req_i) state_d = ST_STOP;
        end
        ST_EXTRST: begin
          if (below_rst_i)                  state_d = ST_PFRST;
          else if (!ext_rst_i && dly_done)  state_d = ST_RUN;
        end
        ST_STOP: begin
          if (mon_stop && below_rst_i)  state_d = ST_PFRST;
          else if (wake_i || qual_hit)  state_d = ST_WAKE;
        end
        ST_WAKE:   if (dly_done) state_d = below_rst_i ? ST_PFRST : ST_RUN;
        default:   state_d = ST_POR;
      endcase
    end
  end

  always_comb begin
    dly_load = ((state_d != state_q) &&
                ((state_d == ST_WARM) || (state_d == ST_WAKE) || (state_d == ST_EXTRST))) ||
               ((state_q == ST_EXTRST) && ext_rst_i);
    unique case (state_d)
      ST_WARM: dly_val = DW'(WARM_CYC - 1);
      ST_WAKE: dly_val = DW'(MON_UP_CYC - 1);
      default: dly_val = DW'(EXT_CYC - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_POR;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stop_dis_q <= 1'b1;
    else if (cfg_we_i) stop_dis_q <= cfg_stop_dis_i;
  end

  // warning seen when the post-stop monitor check completes
  assign wake_warn = (state_q == ST_WAKE) && dly_done && below_warn_i &&
                     !below_rst_i && !below_por_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    warn_q <= 1'b0;
    else if (state_q == ST_POR)     warn_q <= 1'b0;
    else if (qual_hit || wake_warn) warn_q <= 1'b1;
    else if (warn_clr_i)            warn_q <= 1'b0;
  end

  always_comb begin
    unique case (state_q)
      ST_POR:    drv = '{cpu_rst: 1'b1, reg_en: 1'b0, osc_en: 1'b0, mon_en: 1'b0, in_stop: 1'b0};
      ST_PFRST:  drv = '{cpu_rst: 1'b1, reg_en: win,  osc_en: 1'b0, mon_en: win,  in_stop: 1'b0};
      ST_PFCONF: drv = '{cpu_rst: 1'b1, reg_en: 1'b1, osc_en: 1'b0, mon_en: 1'b1, in_stop: 1'b0};
      ST_WARM:   drv = '{cpu_rst: 1'b1, reg_en: 1'b1, osc_en: 1'b1, mon_en: 1'b1, in_stop: 1'b0};
      ST_RUN:    drv = '{cpu_rst: 1'b0, reg_en: 1'b1, osc_en: 1'b1, mon_en: 1'b1, in_stop: 1'b0};
      ST_EXTRST: drv = '{cpu_rst: 1'b1, reg_en: 1'b1, osc_en: 1'b1, mon_en: 1'b1, in_stop: 1'b0};
      ST_STOP:   drv = '{cpu_rst: 1'b0, reg_en: 1'b0, osc_en: 1'b0, mon_en: mon_stop, in_stop: 1'b1};
      ST_WAKE:   drv = '{cpu_rst: 1'b0, reg_en: 1'b1, osc_en: 1'b1, mon_en: 1'b1, in_stop: 1'b1};
      default:   drv = '{cpu_rst: 1'b1, reg_en: 1'b0, osc_en: 1'b0, mon_en: 1'b0, in_stop: 1'b0};
    endcase
  end

  assign cpu_rst_o   = drv.cpu_rst;
  assign reg_en_o    = drv.reg_en;
  assign osc_en_o    = drv.osc_en;
  assign mon_en_o    = drv.mon_en;
  assign in_stop_o   = drv.in_stop;
  assign warn_flag_o = warn_q;
  assign warn_irq_o  = warn_q && warn_irq_en_i;
endmodule

// File: rtl/pwr_guard_seq_chk.sv
`timescale 1ns/1ps
module pwr_guard_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic below_warn_i,
  input logic below_rst_i,
  input logic below_por_i,
  input logic ext_rst_i,
  input logic stop_req_i,
  input logic cpu_rst_o,
  input logic in_stop_o,
  input logic mon_en_o,
  input logic reg_en_o,
  input logic osc_en_o,
  input logic warn_flag_o
);
  // R1
  por_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    below_por_i |=> (cpu_rst_o && !reg_en_o && !osc_en_o && !mon_en_o));

  // R6
  release_warm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> ($past(osc_en_o) && osc_en_o && !$past(below_por_i)));

  // R2
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_o) |-> $past(below_rst_i || below_por_i || ext_rst_i));

  // R7
  warn_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_flag_o) |-> $past(below_warn_i));

  // R4
  osc_needs_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_o |-> reg_en_o);

  // R10
  stop_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_stop_o) |-> $past(stop_req_i));
endmodule

bind pwr_guard_seq pwr_guard_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .below_warn_i(below_warn_i),
  .below_rst_i (below_rst_i),
  .below_por_i (below_por_i),
  .ext_rst_i   (ext_rst_i),
  .stop_req_i  (stop_req_i),
  .cpu_rst_o   (cpu_rst_o),
  .in_stop_o   (in_stop_o),
  .mon_en_o    (mon_en_o),
  .reg_en_o    (reg_en_o),
  .osc_en_o    (osc_en_o),
  .warn_flag_o (warn_flag_o)
);

// File: tb/pwr_guard_seq_tb.sv
`timescale 1ns/1ps
module pwr_guard_seq_tb;
  localparam int RP       = 2;
  localparam int IVL_LOG  = 11;
  localparam int QUAL     = 64;
  localparam int WARM     = 200;
  localparam int EXT      = 16;
  localparam int MON_UP   = 24;

  logic clk = 1'b0;
  logic rst_ni, ring_tick, below_warn, below_rst, below_por, ext_rst;
  logic stop_req, wake, irq_en, warn_clr, cfg_we, cfg_stop_dis;
  logic [1:0] ivl_sel;
  logic cpu_rst, in_stop, mon_en, reg_en, osc_en, warn_flag, warn_irq;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pwr_guard_seq #(
    .IVL_LOG(IVL_LOG), .QUAL_CYC(QUAL), .WARM_CYC(WARM),
    .EXT_CYC(EXT), .MON_UP_CYC(MON_UP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ring_tick_i(ring_tick),
    .below_warn_i(below_warn), .below_rst_i(below_rst), .below_por_i(below_por),
    .ext_rst_i(ext_rst), .stop_req_i(stop_req), .wake_i(wake),
    .ivl_sel_i(ivl_sel), .warn_irq_en_i(irq_en), .warn_clr_i(warn_clr),
    .cfg_we_i(cfg_we), .cfg_stop_dis_i(cfg_stop_dis),
    .cpu_rst_o(cpu_rst), .in_stop_o(in_stop), .mon_en_o(mon_en),
    .reg_en_o(reg_en), .osc_en_o(osc_en), .warn_flag_o(warn_flag),
    .warn_irq_o(warn_irq)
  );

  function automatic int period_cyc(input int sel);
    return ((1 << (IVL_LOG + sel - 1)) + 2) * RP;
  endfunction

  function automatic int flag_exp(input int len);
    return (len >= QUAL) ? 1 : 0;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic recover();
    below_rst = 1'b0;
    while (cpu_rst) step(1);
  endtask

  task automatic measure(input int sel, input string r);
    int n;
    while (mon_en) step(1);
    while (!mon_en) step(1);
    check({r, " window reg_en"}, int'(reg_en), 1);
    check({r, " window osc off"}, int'(osc_en), 0);
    n = 0;
    while (mon_en) begin step(1); n++; end
    check({r, " R4 window length"}, n, 2 * RP);
    while (!mon_en) begin step(1); n++; end
    check({r, " R3 period"}, n, period_cyc(sel));
  endtask

  // ring tick strobe
  initial begin
    int tc;
    tc = 0;
    ring_tick = 1'b0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % RP;
      ring_tick = (tc == 0);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    rst_ni = 1'b0; below_warn = 1'b0; below_rst = 1'b1; below_por = 1'b1;
    ext_rst = 1'b0; stop_req = 1'b0; wake = 1'b0; ivl_sel = 2'd0;
    irq_en = 1'b0; warn_clr = 1'b0; cfg_we = 1'b0; cfg_stop_dis = 1'b1;
    step(3);
    check("R1 reset cpu_rst", int'(cpu_rst), 1);
    check("R1 reset reg_en", int'(reg_en), 0);
    check("R1 reset osc_en", int'(osc_en), 0);
    check("R1 reset mon_en", int'(mon_en), 0);
    check("R1 reset flag", int'(warn_flag), 0);
    rst_ni = 1'b1;
    step(5);
    check("R1 por hold cpu_rst", int'(cpu_rst), 1);
    check("R1 por hold osc_en", int'(osc_en), 0);

    // bring-up, continuous monitoring
    below_por = 1'b0; below_rst = 1'b0;
    while (!osc_en) step(1);
    check("R6 cpu held at warm start", int'(cpu_rst), 1);
    n = 0;
    while (cpu_rst) begin step(1); n++; end
    check("R6 warmup length", n, WARM);

    // R7 / R8 warning qualification, random and edge lengths
    for (int t = 0; t < 10; t++) begin
      int len;
      int en;
      if (t == 0)      len = QUAL - 1;
      else if (t == 1) len = QUAL;
      else             len = 1 + int'($urandom % (2 * QUAL));
      en = int'($urandom % 2);
      irq_en = en[0];
      below_warn = 1'b1;
      step(len);
      below_warn = 1'b0;
      check("R7 flag after run", int'(warn_flag), flag_exp(len));
      check("R8 irq gating", int'(warn_irq), flag_exp(len) & en);
      step(3);
      check("R7 flag sticky", int'(warn_flag), flag_exp(len));
      warn_clr = 1'b1; step(1); warn_clr = 1'b0;
      check("R7 flag cleared", int'(warn_flag), 0);
    end

    // R9 other reset source
    ext_rst = 1'b1; step(1);
    check("R9 ext cpu_rst", int'(cpu_rst), 1);
    check("R9 ext osc on", int'(osc_en), 1);
    check("R9 ext reg on", int'(reg_en), 1);
    step(5);
    ext_rst = 1'b0;
    n = 0;
    while (cpu_rst) begin step(1); n++; end
    check("R9 ext release", n, EXT);
    check("R9 within 20", int'(n <= 20), 1);

    // R2 run detection
    below_rst = 1'b1; step(1);
    check("R2 cpu_rst", int'(cpu_rst), 1);
    check("R2 osc off", int'(osc_en), 0);
    check("R2 monitor continuous", int'(mon_en), 1);

    // R3 / R4 periodic intervals
    ivl_sel = 2'd1; measure(1, "sel1");
    ivl_sel = 2'd2; measure(2, "sel2");
    ivl_sel = 2'd3; measure(3, "sel3");
    ivl_sel = 2'd1;
    while (mon_en) step(1);

    // R5 confirmation tick fails
    while (!mon_en) step(1);
    below_rst = 1'b0;
    step(2 * RP);
    check("R5 confirm monitor on", int'(mon_en), 1);
    below_rst = 1'b1;
    step(RP);
    check("R5 failed confirm osc", int'(osc_en), 0);
    check("R5 failed confirm mon", int'(mon_en), 0);
    check("R5 failed confirm rst", int'(cpu_rst), 1);

    // R5 confirmation passes
    below_rst = 1'b0;
    while (!mon_en) step(1);
    n = 0;
    while (!osc_en) begin step(1); n++; end
    check("R5 window plus confirm", n, 3 * RP);
    n = 0;
    while (cpu_rst) begin step(1); n++; end
    check("R6 warmup after periodic", n, WARM);
    ivl_sel = 2'd0;

    // R10 stop with monitor off
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    check("R10 in stop", int'(in_stop), 1);
    check("R10 mon off", int'(mon_en), 0);
    check("R10 reg off", int'(reg_en), 0);
    check("R10 osc off", int'(osc_en), 0);
    below_warn = 1'b1; below_rst = 1'b1;
    step(3 * QUAL);
    check("R10 reset ignored", int'(cpu_rst), 0);
    check("R10 warning ignored", int'(warn_flag), 0);
    check("R10 still stopped", int'(in_stop), 1);
    below_rst = 1'b0;

    // R11 wake with warning present
    wake = 1'b1; step(1); wake = 1'b0;
    check("R11 wake mon on", int'(mon_en), 1);
    check("R11 wake osc on", int'(osc_en), 1);
    step(MON_UP - 1);
    check("R11 still stopped", int'(in_stop), 1);
    step(1);
    check("R11 stop left", int'(in_stop), 0);
    check("R11 flag on exit", int'(warn_flag), 1);
    check("R11 running", int'(cpu_rst), 0);
    below_warn = 1'b0;
    warn_clr = 1'b1; step(1); warn_clr = 1'b0;

    // R11 wake with reset-level supply
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    below_rst = 1'b1; step(4);
    wake = 1'b1; step(1); wake = 1'b0;
    step(MON_UP - 1);
    check("R11 no reset before check", int'(cpu_rst), 0);
    step(1);
    check("R11 reset after check", int'(cpu_rst), 1);
    recover();

    // R12 stop with monitor kept on
    cfg_we = 1'b1; cfg_stop_dis = 1'b0; step(1); cfg_we = 1'b0;
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    check("R12 mon on in stop", int'(mon_en), 1);
    check("R12 reg off in stop", int'(reg_en), 0);
    below_rst = 1'b1; step(1);
    check("R12 reset in stop", int'(cpu_rst), 1);
    recover();

    // R1 power-on level in run
    below_por = 1'b1; step(1);
    check("R1 por cpu_rst", int'(cpu_rst), 1);
    check("R1 por reg off", int'(reg_en), 0);
    check("R1 por osc off", int'(osc_en), 0);
    check("R1 por mon off", int'(mon_en), 0);

    summary();
    $finish;
  end
endmodule